// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 512-word, 18-bit first-in first-out buffer. It has separate write and read clocks, and the two clocks may share a source or be unrelated. Words enter on write-clock edges and leave through a registered output on read-clock edges. Four active-low flags report the state of the buffer: empty, full, almost-empty and almost-full.

Both thresholds are set by offsets held in programmable registers. A third register holds a control word. The load-select input routes accesses to these registers instead of the buffer: writes take the register value from the data input, and reads place the register contents on the data output.

A read needs more than the primary read enable. It is always blocked while the buffer is empty. In enhanced mode it also needs an active-high second enable. If control bit 5 is set in enhanced mode, it also needs the output enable to be active, so that no word is consumed while the outputs are not driving.

Top module: `dcf_top`

## Requirements
- R1: After asynchronous reset, `emptyN` is 0, `fullN` is 1, `almostEmptyN` is 0, `almostFullN` is 1 and `dataOut` is 0. Both offsets read back as 63 and the control word reads back as 0.
- R2: With `ldSel` high, `rdEnN` low and the buffer not empty, each `rdClk` rising edge loads the oldest unread word into `dataOut`, in write order. While `rdEnN` is high, `dataOut` holds its value.
- R3: While `emptyN` is low, read requests do not change `dataOut` or consume any word. After a word is written into an empty buffer, `emptyN` returns high within four `rdClk` edges.
- R4: When `enhModeN` is low, a read also needs `rdEn2` high. A read blocked this way leaves `dataOut` unchanged and consumes no word.
- R5: When `enhModeN` is low and control-word bit 5 is 1, `outEnN` high blocks reads. The read position does not advance.
- R6: Every bit of `dataOutDrive` equals the inverse of `outEnN`. With `enhModeN` high, `outEnN` has no effect on reads: a word read while the outputs are off stays in `dataOut` until a later read replaces it.
- R7: With `ldSel` low, a write (`wrEn` high) updates a programmable register, and a read (`rdEnN` low) copies a register to `dataOut`. Such a write does not enter the buffer. The write side and the read side each step through the registers in the order almost-empty offset, almost-full offset, control word, then wrap back to the first. Offsets keep data bits 8..0 and read back 0 in bits 17..9. The control word keeps all 18 bits.
- R8: `almostEmptyN` is low exactly when the number of stored words, as seen in the read domain, is at or below the almost-empty offset.
- R9: `fullN` goes low when 512 words are stored. A write while full is discarded.
- R10: `almostFullN` is low exactly when the free space, as seen in the write domain, is at or below the almost-full offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable, active high |
| ldSel | input | 1 | High: buffer access; low: programmable-register access |
| dataIn | input | 18 | Write data or register value |
| rdEnN | input | 1 | Primary read enable, active low |
| rdEn2 | input | 1 | Second read enable, active high, used in enhanced mode |
| enhModeN | input | 1 | Enhanced mode select, active low |
| outEnN | input | 1 | Output enable, active low |
| dataOut | output | 18 | Output register |
| dataOutDrive | output | 18 | Per-bit indication that the output is driven |
| emptyN | output | 1 | Empty flag, active low |
| fullN | output | 1 | Full flag, active low |
| almostEmptyN | output | 1 | Almost-empty flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low |

## Verification
Reads are tried in five situations: a normal drain in order, reads while empty, reads with the primary enable idle, reads in enhanced mode with the second enable low, and reads with the outputs off under each mode setting. Each blocked-read case is followed by a read that must return the word that was held back. A wrong case therefore shows either as a changed output or as a skipped word.

Register traffic writes offsets with junk in the upper bits and then writes a fourth time. This separates field masking from correct wrap of the register order. The threshold flags are checked one word either side of each offset, which catches an off-by-one in the comparison. A fill of 512 words, followed by an extra write and a full drain, shows whether the write at full was really discarded.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef struct packed {
    logic fifoWrite;
    logic regWrite;
  } wrStrobe_t;

  typedef struct packed {
    logic fifoRead;
    logic regRead;
  } rdStrobe_t;

  typedef enum logic [1:0] {
    REG_AE   = 2'd0,
    REG_AF   = 2'd1,
    REG_CTRL = 2'd2
  } regSel_t;

  localparam int OE_GATE_BIT = 5;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              ldSel,
  input  logic              rdEnN,
  input  logic              rdEn2,
  input  logic              enhModeN,
  input  logic              outEnN,
  input  logic              oeGateBit,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              fullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync, rdBinSync, usedW, freeW;
  logic             isFull;

  assign rdBinSync = fromGray(rdGraySync);
  assign usedW     = wrBin - rdBinSync;
  assign freeW     = DEPTH_P - usedW;
  assign isFull    = (usedW == DEPTH_P);

  assign wrStb.fifoWrite = wrEn & ldSel & ~isFull;
  assign wrStb.regWrite  = wrEn & ~ldSel;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrStb.fifoWrite) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign fullN       = ~isFull;
  assign almostFullN = ~(freeW <= {1'b0, afOffset});

  // read domain
  logic [PTR_W-1:0] rdBin, rdGray, wrGraySync, wrBinSync, usedR;
  logic             isEmpty, rdQual;

  assign wrBinSync = fromGray(wrGraySync);
  assign usedR     = wrBinSync - rdBin;
  assign isEmpty   = (usedR == '0);

  assign rdQual = ~rdEnN
                & (enhModeN | rdEn2)
                & (enhModeN | ~oeGateBit | ~outEnN);

  assign rdStb.fifoRead = rdQual & ldSel & ~isEmpty;
  assign rdStb.regRead  = ~rdEnN & ~ldSel;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdStb.fifoRead) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  assign rdAddr       = rdBin[ADDR_W-1:0];
  assign emptyN       = ~isEmpty;
  assign almostEmptyN = ~(usedR <= {1'b0, aeOffset});

  dcf_sync2 #(.W(PTR_W)) u_syncWrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );
  dcf_sync2 #(.W(PTR_W)) u_syncRdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  // R3: an empty buffer never lets the read position move
  assert_no_underrun_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdBin));

  // R3: the crossing pointer changes by at most one bit per edge
  assert_gray_step_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R9: a full buffer never lets the write position move
  assert_no_overflow_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrBin));

  // R5: outputs off under the gate bit in enhanced mode hold the read position
  assert_oe_gate_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!enhModeN && oeGateBit && outEnN) |=> $stable(rdBin));

  // R4: second enable low in enhanced mode holds the read position
  assert_second_enable_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    (!enhModeN && !rdEn2) |=> $stable(rdBin));
endmodule

// File: rtl/dcf_datapath.sv
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 18
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] aeOffset,
  output logic [ADDR_W-1:0] afOffset,
  output logic              oeGateBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] OFFSET_RST = ADDR_W'(DEPTH / 8 - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ctrlWord, regView;
  regSel_t           wrRegIdx, rdRegIdx;

  function automatic regSel_t nextReg(input regSel_t r);
    unique case (r)
      REG_AE:  return REG_AF;
      REG_AF:  return REG_CTRL;
      default: return REG_AE;
    endcase
  endfunction

  always_ff @(posedge wrClk) begin
    if (wrStb.fifoWrite) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOffset <= OFFSET_RST;
      afOffset <= OFFSET_RST;
      ctrlWord <= '0;
      wrRegIdx <= REG_AE;
    end else if (wrStb.regWrite) begin
      unique case (wrRegIdx)
        REG_AE:  aeOffset <= dataIn[ADDR_W-1:0];
        REG_AF:  afOffset <= dataIn[ADDR_W-1:0];
        default: ctrlWord <= dataIn;
      endcase
      wrRegIdx <= nextReg(wrRegIdx);
    end
  end

  always_comb begin
    unique case (rdRegIdx)
      REG_AE:  regView = DATA_W'(aeOffset);
      REG_AF:  regView = DATA_W'(afOffset);
      default: regView = ctrlWord;
    endcase
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      rdRegIdx <= REG_AE;
    end else if (rdStb.fifoRead) begin
      dataOut  <= mem[rdAddr];
    end else if (rdStb.regRead) begin
      dataOut  <= regView;
      rdRegIdx <= nextReg(rdRegIdx);
    end
  end

  assign oeGateBit = ctrlWord[OE_GATE_BIT];

  // R7: the register index only ever holds one of the three slots
  assert_reg_index_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    wrRegIdx != 2'd3);
endmodule

// File: rtl/dcf_top.sv
module dcf_top
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 18
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              ldSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEnN,
  input  logic              rdEn2,
  input  logic              enhModeN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOutDrive,
  output logic              emptyN,
  output logic              fullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  wrStrobe_t         wrStb;
  rdStrobe_t         rdStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOffset, afOffset;
  logic              oeGateBit;

  dcf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .ldSel(ldSel),
    .rdEnN(rdEnN), .rdEn2(rdEn2), .enhModeN(enhModeN), .outEnN(outEnN),
    .oeGateBit(oeGateBit), .aeOffset(aeOffset), .afOffset(afOffset),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN)
  );

  dcf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut),
    .aeOffset(aeOffset), .afOffset(afOffset), .oeGateBit(oeGateBit)
  );

  assign dataOutDrive = {DATA_W{~outEnN}};

  // R2: an idle primary enable leaves the output register untouched
  assert_hold_output_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEnN |=> $stable(dataOut));
endmodule

// File: tb/dcf_top_bench.sv
`timescale 1ns/100ps
module dcf_top_bench;
  logic        wrClk = 0, rdClk = 0, rstN = 0;
  logic        wrEn = 0, ldSel = 1, rdEnN = 1, rdEn2 = 0, enhModeN = 1, outEnN = 0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut, dataOutDrive;
  logic        emptyN, fullN, almostEmptyN, almostFullN;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 rdClk = ~rdClk;   // 250 MHz read clock
  initial begin
    #1.3;
    forever #3 wrClk = ~wrClk; // unrelated write clock
  end

  dcf_top u_dcf_top (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .ldSel(ldSel),
    .dataIn(dataIn), .rdEnN(rdEnN), .rdEn2(rdEn2), .enhModeN(enhModeN),
    .outEnN(outEnN), .dataOut(dataOut), .dataOutDrive(dataOutDrive),
    .emptyN(emptyN), .fullN(fullN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrWord(input logic [17:0] d);
    @(negedge wrClk); ldSel = 1; wrEn = 1; dataIn = d;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic wrReg(input logic [17:0] d);
    @(negedge wrClk); ldSel = 0; wrEn = 1; dataIn = d;
    @(negedge wrClk); wrEn = 0; ldSel = 1;
  endtask

  task automatic rdPulse();
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); rdEnN = 1;
  endtask

  task automatic rdRegCheck(input string req, input logic [17:0] exp);
    @(negedge rdClk); ldSel = 0;
    rdPulse();
    chk(req, dataOut, exp);
    ldSel = 1;
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  task automatic testReset();
    @(negedge rdClk);
    chk("R1 emptyN", emptyN, 0);
    chk("R1 fullN", fullN, 1);
    chk("R1 almostEmptyN", almostEmptyN, 0);
    chk("R1 almostFullN", almostFullN, 1);
    chk("R1 dataOut", dataOut, 0);
    chk("R6 drive on", dataOutDrive, 18'h3FFFF);
    rdRegCheck("R1 ae offset", 18'd63);
    rdRegCheck("R1 af offset", 18'd63);
    rdRegCheck("R1 control", 18'd0);
  endtask

  task automatic testBasic();
    for (int i = 0; i < 5; i++) wrWord(18'h100 + 18'(i));
    repeat (4) @(negedge rdClk);
    chk("R3 empty clears after write", emptyN, 1);
    for (int i = 0; i < 5; i++) begin
      rdPulse();
      chk("R2 read order", dataOut, 18'h100 + 18'(i));
    end
    chk("R3 empty after drain", emptyN, 0);
    rdPulse(); rdPulse();
    chk("R3 read while empty ignored", dataOut, 18'h104);
    wrWord(18'h2AA);
    settle();
    chk("R2 hold while rdEnN high", dataOut, 18'h104);
    rdPulse();
    chk("R3 word read after empty cleared", dataOut, 18'h2AA);
  endtask

  task automatic testEnhanced();
    wrWord(18'h301); wrWord(18'h302);
    settle();
    enhModeN = 0; rdEn2 = 0;
    rdPulse();
    chk("R4 second enable low blocks", dataOut, 18'h2AA);
    rdEn2 = 1;
    rdPulse();
    chk("R4 blocked word not consumed", dataOut, 18'h301);
    rdPulse();
    chk("R4 next word", dataOut, 18'h302);
    enhModeN = 1;
  endtask

  task automatic testRegs();
    wrReg(18'h3FE03); wrReg(18'h00004); wrReg(18'h20021);
    rdRegCheck("R7 ae offset masked", 18'd3);
    rdRegCheck("R7 af offset", 18'd4);
    rdRegCheck("R7 control full width", 18'h20021);
    chk("R7 register write not buffered", emptyN, 0);
    wrReg(18'h00003); wrReg(18'h00004); wrReg(18'h00020);
    rdRegCheck("R7 wrap to ae", 18'd3);
    rdRegCheck("R7 wrap af", 18'd4);
    rdRegCheck("R7 wrap control", 18'h00020);
  endtask

  task automatic testOeGate();
    wrWord(18'h401); wrWord(18'h402); wrWord(18'h403);
    settle();
    enhModeN = 0; rdEn2 = 1; outEnN = 1;
    @(negedge rdClk);
    chk("R6 drive off", dataOutDrive, 0);
    rdPulse();
    chk("R5 outputs off block read", dataOut, 18'h00020);
    outEnN = 0;
    rdPulse();
    chk("R5 blocked word not consumed", dataOut, 18'h401);
    enhModeN = 1; outEnN = 1;
    rdPulse();
    chk("R6 compatible read with outputs off", dataOut, 18'h402);
    outEnN = 0;
    repeat (2) @(negedge rdClk);
    chk("R6 word kept until enabled", dataOut, 18'h402);
    chk("R6 drive back on", dataOutDrive, 18'h3FFFF);
    rdPulse();
    chk("R6 later read replaces", dataOut, 18'h403);
  endtask

  task automatic testAlmostEmpty();
    for (int i = 0; i < 4; i++) wrWord(18'h500 + 18'(i));
    settle();
    chk("R8 four words above offset 3", almostEmptyN, 1);
    rdPulse();
    chk("R8 three words at offset", almostEmptyN, 0);
    for (int i = 0; i < 3; i++) rdPulse();
    chk("R8 drained", dataOut, 18'h503);
  endtask

  task automatic testFull();
    int bad;
    for (int i = 0; i < 507; i++) wrWord(18'(i * 7 + 5));
    settle();
    chk("R10 free 5 above offset 4", almostFullN, 1);
    wrWord(18'(507 * 7 + 5));
    chk("R10 free 4 at offset", almostFullN, 0);
    for (int i = 508; i < 511; i++) wrWord(18'(i * 7 + 5));
    chk("R9 not full at 511", fullN, 1);
    wrWord(18'(511 * 7 + 5));
    chk("R9 full at 512", fullN, 0);
    wrWord(18'h3FFFF);
    chk("R9 still full after extra write", fullN, 0);
    bad = 0;
    for (int i = 0; i < 512; i++) begin
      rdPulse();
      if (dataOut !== 18'(i * 7 + 5)) bad++;
    end
    chk("R9 all 512 words intact", bad, 0);
    settle();
    chk("R9 extra write discarded", emptyN, 0);
    chk("R10 clears when empty", almostFullN, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge rdClk);
    rstN = 1;
    repeat (3) @(negedge wrClk);
    testReset();
    testBasic();
    testEnhanced();
    testRegs();
    testOeGate();
    testAlmostEmpty();
    testFull();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule